// File: doc/BRIEF.md
# DSP Register Transfer Unit

This block carries out the register-transfer instructions of a 16-bit DSP core. It owns a file of 32 registers, each 16 bits wide. It decodes an opcode word and runs one of three operations. The first copies one register into another. The second loads a full 16-bit immediate that arrives as the next code word. The third loads a sign-extended 8-bit immediate into the accumulator group.

Registers 0x1E and 0x1F hold the middle words of two 40-bit accumulators. Their high parts sit at 0x10 and 0x11, and their low words at 0x1C and 0x1D. When the wide-accumulator mode input is high, a write to a middle word by any of the three operations sign-extends across the whole accumulator. When the mode input is low, the write touches only the middle word.

A host port writes and reads the register file directly, so that surrounding logic can load and inspect the state. Instruction fetch, the ALU and the multiplier are not part of this block.

Top module: `dsp_xfer_unit`

## Requirements
- R1: After reset all 32 registers read 0, and done_o and busy_o are low.
- R2: A move is an opcode with bits 15:10 = 000111. It is accepted when op_valid_i is high and busy_o is low. At that clock edge, the register selected by bits 9:5 takes the value of the register selected by bits 4:0, and done_o is high for the following cycle.
- R3: A long immediate load is an opcode with bits 15:5 = 00000000100, and its destination is bits 4:0. From the cycle after acceptance, busy_o stays high until imm_valid_i is sampled high at a clock edge. At that edge imm_i is written to the destination. In the cycle after that edge, done_o is high and busy_o is low.
- R4: A short immediate load is an opcode with bits 15:11 = 00001. It writes op bits 7:0, sign-extended to 16 bits, to register 0x18 + op bits 10:8. done_o is high in the following cycle.
- R5: Suppose mode40_i is high and an instruction writes register 0x1E (or 0x1F). In the same edge, register 0x10 (or 0x11) becomes 16 copies of bit 15 of the written value, and register 0x1C (or 0x1D) becomes 0.
- R6: When mode40_i is low, an instruction write to 0x1E or 0x1F changes only that register.
- R7: An accepted opcode that matches none of the three encodings changes no register and raises neither done_o nor busy_o. op_valid_i is ignored while busy_o is high.
- R8: A host write (wr_en_i) stores wr_data_i at wr_addr_i without any sign extension. It is dropped if an instruction writes a register in the same cycle.
- R9: rd_data_o shows the register selected by rd_addr_i, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Opcode present |
| op_i | input | 16 | Opcode word |
| imm_valid_i | input | 1 | Immediate code word present |
| imm_i | input | 16 | Immediate code word |
| mode40_i | input | 1 | Wide-accumulator sign-extension mode |
| wr_en_i | input | 1 | Host write enable |
| wr_addr_i | input | 5 | Host write index |
| wr_data_i | input | 16 | Host write data |
| rd_addr_i | input | 5 | Host read index |
| rd_data_o | output | 16 | Host read data |
| busy_o | output | 1 | Waiting for an immediate word |
| done_o | output | 1 | One-cycle pulse after an instruction write |

## Verification
The assertions check the following on every cycle:
- every instruction write lands in its destination;
- a middle-word write in wide mode fills the high part and clears the low part;
- in narrow mode the neighbouring registers keep their values;
- the long load holds busy until the immediate arrives;
- done never coincides with busy.

Only the bench scenarios can show that the opcodes are classified correctly and that the short immediate is sign-extended. They also show that unknown opcodes, and opcodes issued while busy, leave every register untouched, and that host writes lose to instruction writes.

// File: rtl/dsp_xfer_pkg.sv
package dsp_xfer_pkg;
  typedef enum logic [1:0] {K_NONE, K_MOVE, K_LONG, K_SHORT} op_kind_e;
  localparam logic [4:0] ACC_GRP_BASE = 5'h18;
  localparam logic [3:0] ACC_MID_TOP  = 4'hF;  // 0x1E/0x1F
  localparam logic [3:0] ACC_HI_TOP   = 4'h8;  // 0x10/0x11
  localparam logic [3:0] ACC_LO_TOP   = 4'hE;  // 0x1C/0x1D
endpackage

// File: rtl/dsp_xfer_decode.sv
module dsp_xfer_decode
  import dsp_xfer_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic [DW-1:0] op_i,
  output op_kind_e      kind_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [DW-1:0] simm_o
);
  always_comb begin
    kind_o = K_NONE;
    src_o  = op_i[4:0];
    dst_o  = op_i[4:0];
    simm_o = {{(DW-8){op_i[7]}}, op_i[7:0]};
    if (op_i[15:10] == 6'b000111) begin
      kind_o = K_MOVE;
      dst_o  = op_i[9:5];
    end else if (op_i[15:5] == 11'b00000000100) begin
      kind_o = K_LONG;
    end else if (op_i[15:11] == 5'b00001) begin
      kind_o = K_SHORT;
      dst_o  = ACC_GRP_BASE + {2'b00, op_i[10:8]};
    end
  end
endmodule

// File: rtl/dsp_xfer_regfile.sv
module dsp_xfer_regfile #(
  parameter int DW = 16,
  parameter int AW = 5,
  localparam int NREG = 1 << AW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     pw_en_i,
  input  logic [AW-1:0]            pw_addr_i,
  input  logic [DW-1:0]            pw_data_i,
  input  logic                     xh_en_i,
  input  logic [AW-1:0]            xh_addr_i,
  input  logic [DW-1:0]            xh_data_i,
  input  logic                     xl_en_i,
  input  logic [AW-1:0]            xl_addr_i,
  input  logic                     hw_en_i,
  input  logic [AW-1:0]            hw_addr_i,
  input  logic [DW-1:0]            hw_data_i,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_o[i] <= '0;
      else if (pw_en_i && pw_addr_i == AW'(i))       regs_o[i] <= pw_data_i;
      else if (xh_en_i && xh_addr_i == AW'(i))       regs_o[i] <= xh_data_i;
      else if (xl_en_i && xl_addr_i == AW'(i))       regs_o[i] <= '0;
      else if (hw_en_i && hw_addr_i == AW'(i))       regs_o[i] <= hw_data_i;
    end
  end
endmodule

// File: rtl/dsp_xfer_unit.sv
module dsp_xfer_unit
  import dsp_xfer_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic [DW-1:0] op_i,
  input  logic          imm_valid_i,
  input  logic [DW-1:0] imm_i,
  input  logic          mode40_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int NREG = 1 << AW;

  op_kind_e               kind;
  logic [AW-1:0]          src, dst, long_dst_q;
  logic [DW-1:0]          simm;
  logic [NREG-1:0][DW-1:0] regs;
  logic                   wait_q, done_q;
  logic                   exec_en, ext_en, accept;
  logic [AW-1:0]          exec_dst;
  logic [DW-1:0]          exec_val;

  dsp_xfer_decode #(.DW(DW), .AW(AW)) u_dec (
    .op_i(op_i), .kind_o(kind), .src_o(src), .dst_o(dst), .simm_o(simm)
  );

  assign accept = op_valid_i && !wait_q;

  always_comb begin
    exec_en  = 1'b0;
    exec_dst = dst;
    exec_val = regs[src];
    if (wait_q) begin
      exec_en  = imm_valid_i;
      exec_dst = long_dst_q;
      exec_val = imm_i;
    end else if (accept && kind == K_MOVE) begin
      exec_en = 1'b1;
    end else if (accept && kind == K_SHORT) begin
      exec_en  = 1'b1;
      exec_val = simm;
    end
  end

  assign ext_en = exec_en && mode40_i && (exec_dst[AW-1:1] == ACC_MID_TOP);

  dsp_xfer_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pw_en_i(exec_en), .pw_addr_i(exec_dst), .pw_data_i(exec_val),
    .xh_en_i(ext_en), .xh_addr_i({ACC_HI_TOP, exec_dst[0]}),
    .xh_data_i({DW{exec_val[DW-1]}}),
    .xl_en_i(ext_en), .xl_addr_i({ACC_LO_TOP, exec_dst[0]}),
    .hw_en_i(wr_en_i && !exec_en), .hw_addr_i(wr_addr_i), .hw_data_i(wr_data_i),
    .regs_o(regs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q     <= 1'b0;
      done_q     <= 1'b0;
      long_dst_q <= '0;
    end else begin
      done_q <= exec_en;
      if (wait_q) begin
        if (imm_valid_i) wait_q <= 1'b0;
      end else if (accept && kind == K_LONG) begin
        wait_q     <= 1'b1;
        long_dst_q <= dst;
      end
    end
  end

  assign rd_data_o = regs[rd_addr_i];
  assign busy_o    = wait_q;
  assign done_o    = done_q;
endmodule

// File: rtl/dsp_xfer_unit_chk.sv
module dsp_xfer_unit_chk #(
  parameter int DW = 16,
  parameter int AW = 5,
  localparam int NREG = 1 << AW
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    op_valid_i,
  input logic [DW-1:0]           op_i,
  input logic                    imm_valid_i,
  input logic                    mode40_i,
  input logic                    busy_o,
  input logic                    done_o,
  input logic                    exec_en,
  input logic [AW-1:0]           exec_dst,
  input logic [DW-1:0]           exec_val,
  input logic [NREG-1:0][DW-1:0] regs
);
  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_en |=> regs[$past(exec_dst)] == $past(exec_val));

  assert_long_enters_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && op_valid_i && op_i[15:5] == 11'b00000000100) |=> busy_o);

  assert_long_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !imm_valid_i) |=> busy_o);

  assert_long_finish_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && imm_valid_i) |=> (!busy_o && done_o));

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_wide_extend_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en && mode40_i && exec_dst[AW-1:1] == 4'hF) |=>
      (regs[{4'h8, $past(exec_dst[0])}] == {DW{$past(exec_val[DW-1])}}) &&
      (regs[{4'hE, $past(exec_dst[0])}] == '0));

  assert_narrow_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en && !mode40_i && exec_dst[AW-1:1] == 4'hF) |=>
      (regs[{4'h8, $past(exec_dst[0])}] == $past(regs[{4'h8, exec_dst[0]}])) &&
      (regs[{4'hE, $past(exec_dst[0])}] == $past(regs[{4'hE, exec_dst[0]}])));
endmodule

bind dsp_xfer_unit dsp_xfer_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_i(op_i),
  .imm_valid_i(imm_valid_i), .mode40_i(mode40_i), .busy_o(busy_o), .done_o(done_o),
  .exec_en(exec_en), .exec_dst(exec_dst), .exec_val(exec_val), .regs(regs)
);

// File: tb/dsp_xfer_unit_tb.sv
module dsp_xfer_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0, imm_valid_i = 1'b0, mode40_i = 1'b0, wr_en_i = 1'b0;
  logic [15:0] op_i = '0, imm_i = '0, wr_data_i = '0;
  logic [4:0]  wr_addr_i = '0, rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        busy_o, done_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] exp_q [32];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dsp_xfer_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_i(op_i),
    .imm_valid_i(imm_valid_i), .imm_i(imm_i), .mode40_i(mode40_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model_write(logic [4:0] d, logic [15:0] v, logic m40);
    exp_q[d] = v;
    if (m40 && d[4:1] == 4'hF) begin
      exp_q[{4'h8, d[0]}] = {16{v[15]}};
      exp_q[{4'hE, d[0]}] = '0;
    end
  endfunction

  function automatic logic [15:0] op_move(logic [4:0] d, logic [4:0] s);
    return {6'b000111, d, s};
  endfunction
  function automatic logic [15:0] op_long(logic [4:0] d);
    return {11'b00000000100, d};
  endfunction
  function automatic logic [15:0] op_short(logic [2:0] d, logic [7:0] i);
    return {5'b00001, d, i};
  endfunction

  task automatic check_regs(string req);
    for (int a = 0; a < 32; a++) begin
      rd_addr_i = 5'(a);
      #1;
      check(req, rd_data_o, exp_q[a]);
    end
  endtask

  // Opcode issued at a negedge, result inspected at the next negedge.
  task automatic issue(logic [15:0] op, logic m40, logic exp_done, string req);
    @(negedge clk_i);
    op_valid_i = 1'b1; op_i = op; mode40_i = m40;
    @(negedge clk_i);
    op_valid_i = 1'b0;
    check({req, " done"}, {15'b0, done_o}, {15'b0, exp_done});
  endtask

  task automatic run_move(logic [4:0] d, logic [4:0] s, logic m40);
    logic [15:0] v = exp_q[s];
    issue(op_move(d, s), m40, 1'b1, "R2");
    model_write(d, v, m40);
  endtask

  task automatic run_short(logic [2:0] d, logic [7:0] i, logic m40);
    issue(op_short(d, i), m40, 1'b1, "R4");
    model_write(5'h18 + {2'b0, d}, {{8{i[7]}}, i}, m40);
  endtask

  task automatic run_long(logic [4:0] d, logic [15:0] v, logic m40, int gap);
    issue(op_long(d), m40, 1'b0, "R3");
    check("R3 busy", {15'b0, busy_o}, 16'd1);
    for (int k = 0; k < gap; k++) begin
      // opcode during wait must be ignored (R7)
      op_valid_i = 1'b1; op_i = op_move(5'd1, 5'd2);
      @(negedge clk_i);
      op_valid_i = 1'b0;
      check("R3 busy hold", {15'b0, busy_o}, 16'd1);
      check("R7 no done while busy", {15'b0, done_o}, 16'd0);
    end
    imm_valid_i = 1'b1; imm_i = v; mode40_i = m40;
    @(negedge clk_i);
    imm_valid_i = 1'b0;
    check("R3 done", {15'b0, done_o}, 16'd1);
    check("R3 busy fall", {15'b0, busy_o}, 16'd0);
    model_write(d, v, m40);
  endtask

  task automatic host_write(logic [4:0] a, logic [15:0] v);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    exp_q[a] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int a = 0; a < 32; a++) exp_q[a] = '0;
    #(CLK_PERIOD * 2 + 2);
    check("R1 busy", {15'b0, busy_o}, 16'd0);
    check("R1 done", {15'b0, done_o}, 16'd0);
    check_regs("R1 reset");
    rst_ni = 1'b1;

    // R8, R9: host port
    host_write(5'd3, 16'hBEEF);
    host_write(5'h1E, 16'h8001);  // raw, no extension
    check_regs("R8 host write");

    // R2 move
    run_move(5'd7, 5'd3, 1'b0);
    check_regs("R2 move");

    // R5 wide: move negative value into 0x1E
    host_write(5'h10, 16'h1234); host_write(5'h1C, 16'h5678);
    run_move(5'h1E, 5'd3, 1'b1);
    check_regs("R5 wide neg");
    // R6 narrow: short load into 0x1F leaves 0x11/0x1D
    host_write(5'h11, 16'hAAAA); host_write(5'h1D, 16'h5555);
    run_short(3'd7, 8'h80, 1'b0);
    check_regs("R6 narrow");
    // R4 sign extension, positive and negative
    run_short(3'd0, 8'h7F, 1'b0);
    run_short(3'd3, 8'hFF, 1'b1);
    check_regs("R4 short");
    // R5 wide positive via long load into 0x1F
    run_long(5'h1F, 16'h7FFF, 1'b1, 3);
    check_regs("R5 wide pos");
    run_long(5'd9, 16'hC0DE, 1'b0, 0);
    check_regs("R3 long");

    // R7 unknown opcode
    issue(16'h1234, 1'b1, 1'b0, "R7");
    check("R7 busy", {15'b0, busy_o}, 16'd0);
    check_regs("R7 unknown");

    // R8 host write loses to instruction write in the same cycle
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 5'd20; wr_data_i = 16'hDEAD;
    op_valid_i = 1'b1; op_i = op_short(3'd1, 8'h05); mode40_i = 1'b0;
    @(negedge clk_i);
    wr_en_i = 1'b0; op_valid_i = 1'b0;
    model_write(5'h19, 16'h0005, 1'b0);
    check_regs("R8 collision");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int sel = $urandom_range(0, 4);
      logic m40 = 1'($urandom);
      logic [4:0] d = 5'($urandom);
      if ($urandom_range(0, 3) == 0) d = {4'hF, 1'($urandom)};
      case (sel)
        0: run_move(d, 5'($urandom), m40);
        1: run_short(3'($urandom), 8'($urandom), m40);
        2: run_long(d, 16'($urandom), m40, $urandom_range(0, 2));
        3: issue({6'b000100, 10'($urandom)}, m40, 1'b0, "R7 random");
        default: host_write(5'($urandom), 16'($urandom));
      endcase
      if (it % 10 == 0) check_regs("R2 R4 R5 R6 random");
    end
    check_regs("R9 final");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule